// File: doc/BRIEF.md
# Power-On Strap Latch Controller

This block manages a group of shared pins that serve as configuration inputs just after power comes up and as clock outputs from then on. Once the supply-good input goes high, the block keeps every pin driver switched off for a fixed sampling window, measured in reference-clock cycles. During that window, external pull resistors set each pin's level. On the last cycle of the window, the synchronised level of each pin is stored as one configuration bit. In that same clock cycle, the pin drivers are turned on and a ready flag is raised.

One of the stored bits selects how a separate pin behaves. With the bit at 1, that pin drives a reference clock. With the bit at 0, it acts as a stop-control input. The stored bits and the ready flag can only be cleared by the supply-good input going low, which models a full power cycle. If supply-good drops at any point, inside or after the window, everything returns to its power-up state. When supply-good returns, a new full window starts.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While supply_good is low, on every clock edge pin_oe, strap_cfg, cfg_ready, ref_clk_oe and stop_in_en are all cleared to 0.
- R2: During the sampling window, meaning after fewer than WINDOW_CYCLES rising edges with supply_good high, pin_oe is all zeros and cfg_ready is 0.
- R3: cfg_ready and all bits of pin_oe go high together on the WINDOW_CYCLES-th rising edge with supply_good high, counted since supply_good was last low.
- R4: Each bit strap_cfg[i] equals the level on pin_in[i] at the end of the window. This holds when the pin has been steady for at least SYNC_STAGES+1 cycles before the final edge.
- R5: Once cfg_ready is high, changes on pin_in have no effect on strap_cfg.
- R6: Once cfg_ready is high, it stays high and strap_cfg stays constant for as long as supply_good remains high.
- R7: If supply_good drops, either during or after the window, all outputs are cleared on the next edge. When supply_good returns, a new window of the full length runs and the pins are captured again.
- R8: Bit MODE_IDX of strap_cfg (bit 2 by default) selects the alternate pin function. When the bit is 1, ref_clk_oe=1 and stop_in_en=0. When it is 0, ref_clk_oe=0 and stop_in_en=1. Before cfg_ready goes high, both are 0.
- R9: Pin levels earlier in the window are ignored. A pin changed as late as SYNC_STAGES+1 edges before the end of the window is captured at its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_good | input | 1 | High while the supply is valid; low acts as a power-cycle reset |
| pin_in | input | NUM_PINS | Levels read back from the shared pins |
| pin_oe | output | NUM_PINS | Driver enable for each shared pin; 0 means high impedance |
| strap_cfg | output | NUM_PINS | Captured configuration bits |
| cfg_ready | output | 1 | High once the configuration has been captured and the drivers are enabled |
| ref_clk_oe | output | 1 | Driver enable for the alternate pin as a reference clock output |
| stop_in_en | output | 1 | Alternate pin acts as the stop-control input |

## Verification
Power-up is run with several strap patterns: one with the mode bit set, one with it clear, and one with mixed bits. These show that each bit is stored in its own position and drives the alternate-function outputs the right way. One pattern changes the pins midway through the window and another changes them only three edges before the end. Together they separate "captured at the end" from "captured early", and show how many synchroniser stages lie in front of the capture. Each run checks the cycle just before and the cycle just after the window closes, which pins the latency to exactly WINDOW_CYCLES edges. The pins are also toggled after ready goes high, and supply_good is dropped both inside and after the window. These two tests tell a capture held until power is removed apart from one that a later pin change, or an incomplete window, could disturb.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Phases of the sampling window controller.
  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_RUN    = 1'b1
  } phase_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (por) stage_q[0] <= '0;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (por) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/window_timer.sv
module window_timer
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic por,
  output logic window_end
);
  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;

  // A single-cycle strobe on the final edge of the window.
  assign window_end = !por && (phase_q == PH_SAMPLE) && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (por) begin
      phase_q <= PH_SAMPLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_SAMPLE) begin
      if (cnt_q == LAST) phase_q <= PH_RUN;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NUM_PINS = 5,
  parameter int MODE_IDX = 2
) (
  input  logic                clk,
  input  logic                por,
  input  logic                load,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] strap_cfg,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                cfg_ready,
  output logic                ref_clk_oe,
  output logic                stop_in_en
);
  always_ff @(posedge clk) begin
    if (por) begin
      strap_cfg  <= '0;
      pin_oe     <= '0;
      cfg_ready  <= 1'b0;
      ref_clk_oe <= 1'b0;
      stop_in_en <= 1'b0;
    end else if (load) begin
      strap_cfg  <= pin_sync;
      pin_oe     <= '1;
      cfg_ready  <= 1'b1;
      ref_clk_oe <= pin_sync[MODE_IDX];
      stop_in_en <= !pin_sync[MODE_IDX];
    end
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl #(
  parameter int NUM_PINS      = 5,
  parameter int WINDOW_CYCLES = 28636,
  parameter int SYNC_STAGES   = 2,
  parameter int MODE_IDX      = 2
) (
  input  logic                clk,
  input  logic                supply_good,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] strap_cfg,
  output logic                cfg_ready,
  output logic                ref_clk_oe,
  output logic                stop_in_en
);
  logic                por;
  logic                window_end;
  logic [NUM_PINS-1:0] pin_sync;

  // The supply indication is the only source of reset.
  assign por = !supply_good;

  strap_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por   (por),
    .d_in  (pin_in),
    .d_out (pin_sync)
  );

  window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk        (clk),
    .por        (por),
    .window_end (window_end)
  );

  strap_capture #(.NUM_PINS(NUM_PINS), .MODE_IDX(MODE_IDX)) u_capture (
    .clk        (clk),
    .por        (por),
    .load       (window_end),
    .pin_sync   (pin_sync),
    .strap_cfg  (strap_cfg),
    .pin_oe     (pin_oe),
    .cfg_ready  (cfg_ready),
    .ref_clk_oe (ref_clk_oe),
    .stop_in_en (stop_in_en)
  );
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk #(
  parameter int NUM_PINS      = 5,
  parameter int WINDOW_CYCLES = 28636,
  parameter int MODE_IDX      = 2
) (
  input logic                clk,
  input logic                supply_good,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] strap_cfg,
  input logic                cfg_ready,
  input logic                ref_clk_oe,
  input logic                stop_in_en
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  logic [CW-1:0] seen_q;

  // Counts edges with supply high, saturating at the window length.
  always_ff @(posedge clk) begin
    if (!supply_good)                      seen_q <= '0;
    else if (seen_q != CW'(WINDOW_CYCLES)) seen_q <= seen_q + 1'b1;
  end

  // R1
  off_clears_chk: assert property (@(posedge clk)
    !supply_good |=> (pin_oe == '0 && strap_cfg == '0 && !cfg_ready && !ref_clk_oe && !stop_in_en));

  // R2
  window_ready_chk: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_ready == (seen_q == CW'(WINDOW_CYCLES)));

  // R3
  oe_with_ready_chk: assert property (@(posedge clk) disable iff (!supply_good)
    (cfg_ready ? (pin_oe == '1) : (pin_oe == '0)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!supply_good)
    (cfg_ready && supply_good) |=> (cfg_ready && $stable(strap_cfg)));

  // R8
  mode_sel_chk: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_ready ? (ref_clk_oe == strap_cfg[MODE_IDX] && stop_in_en == !strap_cfg[MODE_IDX])
              : (!ref_clk_oe && !stop_in_en));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .WINDOW_CYCLES(WINDOW_CYCLES), .MODE_IDX(MODE_IDX)
) u_chk (
  .clk         (clk),
  .supply_good (supply_good),
  .pin_oe      (pin_oe),
  .strap_cfg   (strap_cfg),
  .cfg_ready   (cfg_ready),
  .ref_clk_oe  (ref_clk_oe),
  .stop_in_en  (stop_in_en)
);

// File: tb/strap_latch_ctrl_bench.sv
module strap_latch_ctrl_bench;
  localparam int N = 5;
  localparam int W = 40;

  typedef struct {
    int         cyc;
    logic       rdy;
    logic [N-1:0] oe;
    logic [N-1:0] cfg;
    logic       refo;
    logic       stp;
    string      req;
  } exp_t;

  logic         clk = 1'b0;
  logic         supply_good = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_oe, strap_cfg;
  logic         cfg_ready, ref_clk_oe, stop_in_en;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #5 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  strap_latch_ctrl #(.NUM_PINS(N), .WINDOW_CYCLES(W), .SYNC_STAGES(2), .MODE_IDX(2)) u_strap_latch_ctrl (
    .clk(clk), .supply_good(supply_good), .pin_in(pin_in), .pin_oe(pin_oe),
    .strap_cfg(strap_cfg), .cfg_ready(cfg_ready), .ref_clk_oe(ref_clk_oe), .stop_in_en(stop_in_en)
  );

  task automatic push(input int c, input logic r, input logic [N-1:0] cfg, input string req);
    exp_t e;
    e.cyc = c; e.rdy = r; e.oe = r ? '1 : '0; e.cfg = cfg;
    e.refo = r & cfg[2]; e.stp = r & !cfg[2]; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compare on the falling edge, away from output updates.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cfg_ready !== e.rdy || pin_oe !== e.oe || strap_cfg !== e.cfg ||
          ref_clk_oe !== e.refo || stop_in_en !== e.stp) begin
        failures++;
        $display("FAIL %s cyc=%0d actual rdy=%b oe=%b cfg=%b ref=%b stop=%b expected rdy=%b oe=%b cfg=%b ref=%b stop=%b",
                 e.req, cyc, cfg_ready, pin_oe, strap_cfg, ref_clk_oe, stop_in_en,
                 e.rdy, e.oe, e.cfg, e.refo, e.stp);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      report();
    end
  end

  initial begin
    int n;
    @(negedge clk);
    // R1: power off holds everything cleared.
    push(3, 1'b0, '0, "R1");
    wait_until(5);

    // Power-up with mode bit set (bit2=1).
    pin_in = 5'b10110;
    supply_good = 1'b1; n = cyc;
    push(n + 1,     1'b0, '0,       "R2");
    push(n + W - 1, 1'b0, '0,       "R2");
    push(n + W,     1'b1, 5'b10110, "R3 R4 R8");
    push(n + W + 10, 1'b1, 5'b10110, "R5 R6");
    wait_until(n + W + 1);
    pin_in = 5'b01001;
    wait_until(n + W + 12);

    // R7: drop after the window.
    supply_good = 1'b0; n = cyc;
    push(n + 1, 1'b0, '0, "R7");
    push(n + 4, 1'b0, '0, "R1 R7");
    wait_until(n + 5);

    // R9: mid-window change, mode bit clear at the end.
    pin_in = 5'b11111;
    supply_good = 1'b1; n = cyc;
    push(n + W - 1, 1'b0, '0,       "R2 R7");
    push(n + W,     1'b1, 5'b01011, "R9 R8");
    wait_until(n + 10);
    pin_in = 5'b01011;
    wait_until(n + W + 3);

    // R7: drop during the window, then a full fresh window.
    supply_good = 1'b0;
    wait_until(cyc + 3);
    pin_in = 5'b00000;
    supply_good = 1'b1; n = cyc;
    push(n + 14, 1'b0, '0, "R2");
    wait_until(n + 15);
    supply_good = 1'b0;
    push(cyc + 1, 1'b0, '0, "R7");
    wait_until(cyc + 3);
    supply_good = 1'b1; n = cyc;
    push(n + W - 1, 1'b0, '0,       "R7 R3");
    push(n + W,     1'b1, 5'b10101, "R9 R4 R8");
    wait_until(n + W - 3);
    pin_in = 5'b10101;
    wait_until(n + W + 1);
    pin_in = 5'b00010;
    push(n + W + 6, 1'b1, 5'b10101, "R5 R6");
    wait_until(n + W + 8);

    done = 1'b1;
    report();
  end
endmodule